// File: doc/BRIEF.md
# Pipelined Burst Static Memory

This block is a clocked static memory that registers every command input on the rising clock edge and returns read data from an output register one cycle later. A new access starts with an address strobe. A two-bit burst counter then moves through four word addresses inside an aligned group of four. The counter steps only when the advance input is asserted. A static pin selects the stepping order: XOR (interleaved) or wrapping increment (linear).

Writes are masked per byte lane. A lane gate qualifies the individual lane enables, and a separate write-all input overrides both. Three chip enables must agree for the device to respond, which allows several instances to share one address space. The output enable acts without a clock. A doze input freezes the block and keeps its contents and its burst position. The three-state data bus is modelled as a data vector plus a drive flag. While the flag is low, the data reads as zero.

Top module: `burst_sram`

## Requirements
- R1: A strobe cycle selects the device only when en_a_n=0, en_b=1 and en_c_n=0. Any other combination produces no drive and writes nothing.
- R2: A read loaded at rising edge k is driven on rdata, with rdrive=1, after edge k+1. The cycle between edge k and edge k+1 shows the state of the previous command.
- R3: With seq_linear=0, beat i of a burst reads the word whose two low address bits are start[1:0] XOR i. The upper bits stay unchanged.
- R4: With seq_linear=1, beat i reads the word whose two low address bits are (start[1:0]+i) mod 4. The upper bits stay unchanged.
- R5: After a deselecting strobe at edge k, the output still shows the prior read after edge k, and rdrive is 0 from edge k+1 on.
- R6: wr_all_n=0 writes every lane, whatever wr_lane_gate_n and wr_lane_n are. A write cycle never drives the output.
- R7: With wr_all_n=1 and wr_lane_gate_n=0, only lanes whose wr_lane_n bit is 0 are written. Lane g is data bits [g*LANE_W +: LANE_W]. With both write inputs high, the cycle is a read.
- R8: While doze=1, commands, strobes and writes are ignored and the burst position is kept. rdrive is 0 from the second edge of doze on. After doze falls, the burst continues from the kept position.
- R9: When neither the strobe nor the advance input is asserted, the current burst word is accessed again.
- R10: out_en_n=1 forces rdrive to 0 and rdata to 0 at once, with no clock edge. Clearing it restores the registered output.
- R11: After reset, rdrive is 0 and rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control registers |
| addr_in | input | ADDR_W | Word address, loaded on a strobe |
| strobe_n | input | 1 | Active-low address strobe, starts a new access |
| step_n | input | 1 | Active-low burst advance |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| wr_all_n | input | 1 | Active-low write of all lanes |
| wr_lane_gate_n | input | 1 | Active-low qualifier for the lane enables |
| wr_lane_n | input | LANES | Active-low per-lane write enables |
| wdata | input | LANES*LANE_W | Write data |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| doze | input | 1 | Freeze, contents and burst position held |
| seq_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| rdata | output | LANES*LANE_W | Read data, zero while not driven |
| rdrive | output | 1 | High when rdata is driven |

## Verification
Bursts start from low address bits 01 and 11, which are the offsets where interleaved and linear orders differ. One start runs in both orders, so a swapped or mis-stepped counter gives a wrong word on some beat. Write patterns cover all-lane writes with every lane enable off, single-lane writes on each lane in turn, and a cycle with the lane enables on but the gate closed. Together these separate the override, the gate and the lane-to-bit mapping. Deselect tests try each wrong chip-enable pattern along with a write attempt. A doze interval placed in mid-burst, with a competing strobe and write, shows whether the burst position and the contents survive.

// File: rtl/burst_sram.sv
`timescale 1ns/100ps
module burst_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr_in,
  input  logic                      strobe_n,
  input  logic                      step_n,
  input  logic                      en_a_n,
  input  logic                      en_b,
  input  logic                      en_c_n,
  input  logic                      wr_all_n,
  input  logic                      wr_lane_gate_n,
  input  logic [LANES-1:0]          wr_lane_n,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic                      out_en_n,
  input  logic                      doze,
  input  logic                      seq_linear,
  output logic [LANES*LANE_W-1:0]   rdata,
  output logic                      rdrive
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0]     mem [DEPTH];
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic              sel_q, act_q, drv_q;
  logic [LANES-1:0]  wr_q;
  logic [DW-1:0]     wd_q, rd_q;

  logic              chip_on;
  logic [LANES-1:0]  lane_mask;
  logic [1:0]        low;
  logic [ADDR_W-1:0] baddr;
  logic              access, is_read;

  assign chip_on   = !en_a_n && en_b && !en_c_n;
  assign lane_mask = !wr_all_n ? {LANES{1'b1}} : (!wr_lane_gate_n ? ~wr_lane_n : {LANES{1'b0}});
  assign low       = seq_linear ? (base_q[1:0] + cnt_q) : (base_q[1:0] ^ cnt_q);
  assign baddr     = {base_q[ADDR_W-1:2], low};
  assign access    = act_q && sel_q;
  assign is_read   = access && (wr_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
      act_q  <= 1'b0;
      wr_q   <= '0;
      wd_q   <= '0;
    end else if (doze) begin
      act_q <= 1'b0;
      wr_q  <= '0;
    end else begin
      act_q <= 1'b1;
      wd_q  <= wdata;
      if (!strobe_n) begin
        base_q <= addr_in;
        cnt_q  <= 2'd0;
        sel_q  <= chip_on;
        wr_q   <= chip_on ? lane_mask : '0;
      end else begin
        if (!step_n) cnt_q <= cnt_q + 2'd1;
        wr_q <= sel_q ? lane_mask : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (access)
      for (int g = 0; g < LANES; g++)
        if (wr_q[g]) mem[baddr][g*LANE_W +: LANE_W] <= wd_q[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      drv_q <= is_read;
      if (is_read) rd_q <= mem[baddr];
    end
  end

  assign rdrive = drv_q && !out_en_n;
  assign rdata  = rdrive ? rd_q : '0;

  AST_READ_ONE_LATE: assert property (@(posedge clk) disable iff (!rst_n) (!doze && !strobe_n && chip_on && lane_mask == '0) |=> ##1 (rdrive || out_en_n)); // R2
  AST_DESELECT_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!doze && !strobe_n && !chip_on) |=> ##1 !rdrive); // R5
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!doze && !strobe_n && chip_on && lane_mask != '0) |=> ##1 !rdrive); // R6
  AST_DOZE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) doze |=> ($stable(base_q) && $stable(cnt_q) && $stable(sel_q))); // R8
  AST_DOZE_DARK: assert property (@(posedge clk) disable iff (!rst_n) doze |=> ##1 !rdrive); // R8
  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n) (!doze && !strobe_n) |=> (baddr == $past(addr_in))); // R3
endmodule

// File: tb/test_burst_sram.sv
`timescale 1ns/100ps
module test_burst_sram;
  localparam int AW = 8;
  localparam int DW = 18;
  localparam logic [2:0] SEL = 3'b010;
  localparam logic [2:0] OFF = 3'b000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic strobe_n = 1'b1, step_n = 1'b1;
  logic en_a_n = 1'b1, en_b = 1'b0, en_c_n = 1'b1;
  logic wr_all_n = 1'b1, wr_lane_gate_n = 1'b1;
  logic [1:0] wr_lane_n = 2'b11;
  logic [DW-1:0] wdata = '0;
  logic out_en_n = 1'b0, doze = 1'b0, seq_linear = 1'b0;
  logic [DW-1:0] rdata;
  logic rdrive;

  logic [DW-1:0] ref_m [1 << AW];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_sram #(.ADDR_W(AW), .LANES(2), .LANE_W(9)) i_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .strobe_n(strobe_n), .step_n(step_n),
    .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n), .wr_all_n(wr_all_n),
    .wr_lane_gate_n(wr_lane_gate_n), .wr_lane_n(wr_lane_n), .wdata(wdata),
    .out_en_n(out_en_n), .doze(doze), .seq_linear(seq_linear), .rdata(rdata), .rdrive(rdrive));

  task automatic see(input string req, input logic edrv, input logic [DW-1:0] ed);
    n_chk++;
    if (rdrive !== edrv || rdata !== ed) begin
      n_bad++;
      $display("FAIL %s: actual drive=%0b data=%h expected drive=%0b data=%h", req, rdrive, rdata, edrv, ed);
    end
  endtask

  task automatic cmd(input logic ld, input logic adv, input logic [AW-1:0] a, input logic [2:0] ce,
                     input logic g, input logic be, input logic [1:0] bw, input logic [DW-1:0] d);
    @(negedge clk);
    strobe_n = ~ld; step_n = ~adv; addr_in = a;
    {en_a_n, en_b, en_c_n} = ce;
    wr_all_n = ~g; wr_lane_gate_n = ~be; wr_lane_n = bw; wdata = d;
  endtask

  task automatic nop();      cmd(1'b0, 1'b0, '0, SEL, 1'b0, 1'b0, 2'b11, '0); endtask
  task automatic adv();      cmd(1'b0, 1'b1, '0, SEL, 1'b0, 1'b0, 2'b11, '0); endtask
  task automatic deselect(); cmd(1'b1, 1'b0, '0, OFF, 1'b0, 1'b0, 2'b11, '0); endtask
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cmd(1'b1, 1'b0, a, SEL, 1'b1, 1'b0, 2'b11, d);
    ref_m[a] = d;
  endtask
  task automatic rd_chk(input logic [AW-1:0] a, input string req);
    deselect();
    cmd(1'b1, 1'b0, a, SEL, 1'b0, 1'b0, 2'b11, '0);
    nop();
    nop();
    see(req, 1'b1, ref_m[a]);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    see("R11", 1'b0, '0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 4; i++) wr(8'h40 + 8'(i), 18'h0A100 + DW'(i * 37));
    for (int i = 0; i < 4; i++) wr(8'h7C + 8'(i), 18'h25300 + DW'(i * 91));
    wr(8'h10, 18'h1C3C3);
    wr(8'h20, 18'h00000);
    deselect();
  endtask

  task automatic t_burst(input logic [AW-1:0] base, input logic lin);
    string req;
    logic [AW-1:0] ea [4];
    req = lin ? "R4" : "R3";
    for (int i = 0; i < 4; i++)
      ea[i] = {base[AW-1:2], lin ? 2'(base[1:0] + 2'(i)) : 2'(base[1:0] ^ 2'(i))};
    seq_linear = lin;
    deselect();
    cmd(1'b1, 1'b0, base, SEL, 1'b0, 1'b0, 2'b11, '0);
    adv();
    see("R2", 1'b0, '0);
    adv();
    see(req, 1'b1, ref_m[ea[0]]);
    adv();
    see(req, 1'b1, ref_m[ea[1]]);
    nop();
    see(req, 1'b1, ref_m[ea[2]]);
    nop();
    see(req, 1'b1, ref_m[ea[3]]);
    deselect();
    see("R9", 1'b1, ref_m[ea[3]]);
    nop();
    see("R5", 1'b1, ref_m[ea[3]]);
    nop();
    see("R5", 1'b0, '0);
  endtask

  task automatic t_select();
    logic [2:0] pats [3];
    pats[0] = 3'b110; pats[1] = 3'b000; pats[2] = 3'b011;
    for (int p = 0; p < 3; p++) begin
      deselect();
      cmd(1'b1, 1'b0, 8'h10, pats[p], 1'b1, 1'b0, 2'b11, 18'h3FFFF);
      nop();
      nop();
      see("R1", 1'b0, '0);
    end
    rd_chk(8'h10, "R1");
  endtask

  task automatic t_global();
    deselect();
    cmd(1'b1, 1'b0, 8'h20, SEL, 1'b1, 1'b1, 2'b11, 18'h2AB55);
    ref_m[8'h20] = 18'h2AB55;
    nop();
    nop();
    see("R6", 1'b0, '0);
    nop();
    see("R6", 1'b1, ref_m[8'h20]);
  endtask

  task automatic t_byte();
    deselect();
    cmd(1'b1, 1'b0, 8'h20, SEL, 1'b0, 1'b1, 2'b10, 18'h15A5A);
    ref_m[8'h20] = {ref_m[8'h20][17:9], 9'h05A};
    nop();
    nop();
    see("R7", 1'b0, '0);
    nop();
    see("R7", 1'b1, ref_m[8'h20]);
    deselect();
    cmd(1'b1, 1'b0, 8'h20, SEL, 1'b0, 1'b1, 2'b01, 18'h3C0F0);
    ref_m[8'h20] = {9'h1E0, ref_m[8'h20][8:0]};
    nop();
    nop();
    nop();
    see("R7", 1'b1, ref_m[8'h20]);
    deselect();
    cmd(1'b1, 1'b0, 8'h20, SEL, 1'b0, 1'b0, 2'b00, 18'h3FFFF);
    nop();
    nop();
    see("R7", 1'b1, ref_m[8'h20]);
  endtask

  task automatic t_doze();
    seq_linear = 1'b0;
    deselect();
    cmd(1'b1, 1'b0, 8'h40, SEL, 1'b0, 1'b0, 2'b11, '0);
    adv();
    cmd(1'b1, 1'b0, 8'h10, SEL, 1'b1, 1'b0, 2'b11, 18'h01234);
    doze = 1'b1;
    see("R8", 1'b1, ref_m[8'h40]);
    cmd(1'b1, 1'b0, 8'h10, SEL, 1'b1, 1'b0, 2'b11, 18'h01234);
    see("R8", 1'b1, ref_m[8'h41]);
    cmd(1'b1, 1'b0, 8'h10, SEL, 1'b1, 1'b0, 2'b11, 18'h01234);
    see("R8", 1'b0, '0);
    adv();
    doze = 1'b0;
    see("R8", 1'b0, '0);
    nop();
    see("R8", 1'b0, '0);
    nop();
    see("R8", 1'b1, ref_m[8'h42]);
    rd_chk(8'h10, "R8");
  endtask

  task automatic t_oe();
    deselect();
    cmd(1'b1, 1'b0, 8'h41, SEL, 1'b0, 1'b0, 2'b11, '0);
    nop();
    nop();
    see("R10", 1'b1, ref_m[8'h41]);
    #0.5 out_en_n = 1'b1;
    #0.5 see("R10", 1'b0, '0);
    out_en_n = 1'b0;
    #0.5 see("R10", 1'b1, ref_m[8'h41]);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_burst(8'h41, 1'b0);
    t_burst(8'h41, 1'b1);
    t_burst(8'h7F, 1'b1);
    t_burst(8'h7F, 1'b0);
    t_select();
    t_global();
    t_byte();
    t_doze();
    t_oe();
    deselect();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule